// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers up to 32 interrupt request lines from peripherals and presents them to a processor on two lines: a normal interrupt output and a fast interrupt output. It has two banks of identical registers. The normal bank sits at byte offsets 0x00 to 0x14 and the fast bank at 0x20 to 0x34. Each bank decides separately how every line is sensed: by level or by edge, and with either polarity. Each bank has its own enable mask and its own write-one-to-clear acknowledge for latched edges. It reports both the raw pending state and the pending state after masking.

Every request line first passes through a two-flop synchroniser. Both banks share the synchronised copy, and each bank applies its own polarity and edge detection to it. Software reaches the registers through a simple port. An access is a single cycle with `busSel` high, and `busWr` selects a write or a read. Read data is registered and appears on `busRdata` in the cycle after the read. An interrupt service loop reads the masked status, handles the lowest set bit and acknowledges it. The loop repeats until the status reads zero.

Register word index (`busAddr[4:2]`), the same in each bank: 0 raw pending (read only), 1 enable mask, 2 clear (write only, reads 0), 3 trigger mode, 4 polarity, 5 masked status (read only). `busAddr[5]` selects the bank: 0 is normal, 1 is fast.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset the mask, mode and polarity registers of both banks read 0, and both `irqOut` and `fastOut` are low.
- R2: The mask (index 1), mode (index 3) and polarity (index 4) registers of each bank read back exactly the last value written. A write to one bank leaves the other bank unchanged.
- R3: With mode bit 0 and polarity bit 0 (level, active high), the raw pending bit follows the input two clock edges after it changes. The masked status equals raw AND mask.
- R4: With mode bit 0 and polarity bit 1 (level, active low), the raw pending bit is set while the input is low and clear while it is high.
- R5: With mode bit 1 and polarity bit 0, a rising input edge sets a pending bit. The bit stays set after the input returns low.
- R6: With mode bit 1 and polarity bit 1, only a falling edge sets the pending bit. A rising edge does not set it, and a change of polarity alone does not set it.
- R7: Writing the clear register (index 2) clears each latched edge bit written as 1. Bits written as 0 are not affected. A clear does not change a level-sensed pending bit.
- R8: When an edge is detected in the same cycle as a clear write for that line, the line stays pending.
- R9: `irqOut` is high exactly when the normal bank's masked status is nonzero. `fastOut` is high exactly when the fast bank's masked status is nonzero. Each bank acts independently of the other.
- R10: Clearing a mask bit removes that line from the masked status and from the output at once, while the raw pending bit keeps its value.
- R11: A read returns its data in the next cycle. Word indices 6 and 7 read 0. Accesses with `busAddr[1:0]` nonzero read 0 and write nothing. Writes to the raw, status and unmapped words change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (6) | Byte address of the register |
| busWdata | input | NUM_LINES (32) | Write data, one bit per line |
| busRdata | output | NUM_LINES (32) | Read data, valid the cycle after a read |
| irqIn | input | NUM_LINES (32) | Asynchronous interrupt request lines |
| irqOut | output | 1 | Normal interrupt to the processor |
| fastOut | output | 1 | Fast interrupt to the processor |

## Verification
The lines are driven in several ways:
- A steady level under each polarity shows the difference between active-high and active-low sensing.
- A short pulse that is gone before the register is read shows the difference between sticky edge capture and level following. It also shows that the normal bank in level mode has already forgotten the pulse.
- A rise and then a fall on a falling-edge line shows that only one direction is latched.
- An edge timed to reach the detector in the same cycle as a clear write shows which of the two wins.

Clear writes with mixed one and zero bits, and mask changes over a latched line, separate acknowledge from masking. Register writes with distinct patterns in each bank show that the two banks are kept apart.

// File: rtl/dic_pkg.sv
package dic_pkg;

  // Two banks: index 0 drives the normal output, index 1 the fast output.
  localparam int NUM_BANKS = 2;

  // Register word index within a bank (byte address bits [4:2]).
  typedef enum logic [2:0] {
    REG_RAW  = 3'd0,
    REG_MASK = 3'd1,
    REG_CLR  = 3'd2,
    REG_MODE = 3'd3,
    REG_POL  = 3'd4,
    REG_STAT = 3'd5
  } regSel_e;

  // Strobes passed from the decoder to the datapath.
  typedef struct packed {
    logic [NUM_BANKS-1:0] wrMask;
    logic [NUM_BANKS-1:0] wrMode;
    logic [NUM_BANKS-1:0] wrPol;
    logic [NUM_BANKS-1:0] wrClr;
    logic                 rdEn;
    logic                 rdHit;
    logic                 rdBank;
    regSel_e              rdSel;
  } strobe_t;

endpackage

// File: rtl/dic_sync.sv
module dic_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dic_ctrl.sv
module dic_ctrl
  import dic_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes
);

  localparam int BANK_BIT = 5;

  logic    upperZero;
  logic    aligned;
  logic    hit;
  logic    bankSel;
  regSel_e regSel;

  generate
    if (ADDR_W > BANK_BIT + 1) begin : g_upper
      assign upperZero = ~|busAddr[ADDR_W-1:BANK_BIT+1];
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign aligned = (busAddr[1:0] == 2'b00);
  assign hit     = upperZero && aligned;
  assign bankSel = busAddr[BANK_BIT];
  assign regSel  = regSel_e'(busAddr[4:2]);

  always_comb begin
    strobes = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (busSel && busWr && hit && (bankSel == 1'(b))) begin
        strobes.wrMask[b] = (regSel == REG_MASK);
        strobes.wrMode[b] = (regSel == REG_MODE);
        strobes.wrPol[b]  = (regSel == REG_POL);
        strobes.wrClr[b]  = (regSel == REG_CLR);
      end
    end
    strobes.rdEn   = busSel && !busWr;
    strobes.rdHit  = hit && (busAddr[4:3] != 2'b11);
    strobes.rdBank = bankSel;
    strobes.rdSel  = regSel;
  end

endmodule

// File: rtl/dic_datapath.sv
module dic_datapath
  import dic_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [NUM_LINES-1:0] busWdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] busRdata,
  output logic [NUM_BANKS-1:0] bankOut
);

  logic [NUM_LINES-1:0] syncd;
  logic [NUM_LINES-1:0] prevSync;

  logic [NUM_BANKS-1:0][NUM_LINES-1:0] maskW, modeW, polW, pendW, statW;

  dic_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(irqIn),
    .syncOut(syncd)
  );

  // Previous synchronised sample, shared by both banks' edge detectors.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSync <= '0;
    else       prevSync <= syncd;
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [NUM_LINES-1:0] maskQ, modeQ, polQ, latchQ;
      logic [NUM_LINES-1:0] activeNow, activePrev, edgeHit, clrBits;

      // Polarity applied to current and previous sample alike, so that a
      // polarity write on a steady input never looks like an edge.
      assign activeNow  = syncd ^ polQ;
      assign activePrev = prevSync ^ polQ;
      assign edgeHit    = activeNow & ~activePrev;
      assign clrBits    = strobes.wrClr[b] ? busWdata : '0;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          maskQ  <= '0;
          modeQ  <= '0;
          polQ   <= '0;
          latchQ <= '0;
        end else begin
          if (strobes.wrMask[b]) maskQ <= busWdata;
          if (strobes.wrMode[b]) modeQ <= busWdata;
          if (strobes.wrPol[b])  polQ  <= busWdata;
          // A new edge outranks a clear in the same cycle.
          latchQ <= modeQ & (edgeHit | (latchQ & ~clrBits));
        end
      end

      assign maskW[b] = maskQ;
      assign modeW[b] = modeQ;
      assign polW[b]  = polQ;
      assign pendW[b] = (modeQ & latchQ) | (~modeQ & activeNow);
      assign statW[b] = pendW[b] & maskQ;
      assign bankOut[b] = |statW[b];
    end
  endgenerate

  // Registered read port: data lands in the cycle after the access.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobes.rdEn) begin
      if (!strobes.rdHit) begin
        busRdata <= '0;
      end else begin
        case (strobes.rdSel)
          REG_RAW:  busRdata <= pendW[strobes.rdBank];
          REG_MASK: busRdata <= maskW[strobes.rdBank];
          REG_MODE: busRdata <= modeW[strobes.rdBank];
          REG_POL:  busRdata <= polW[strobes.rdBank];
          REG_STAT: busRdata <= statW[strobes.rdBank];
          default:  busRdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dic_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 irqOut,
  output logic                 fastOut
);

  strobe_t              strobes;
  logic [NUM_BANKS-1:0] bankOut;

  dic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobes(strobes)
  );

  dic_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busWdata(busWdata),
    .irqIn   (irqIn),
    .busRdata(busRdata),
    .bankOut (bankOut)
  );

  assign irqOut  = bankOut[0];
  assign fastOut = bankOut[1];

endmodule

// File: rtl/dic_checker.sv
module dic_checker #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWr,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [NUM_LINES-1:0] busWdata,
  input logic [NUM_LINES-1:0] busRdata,
  input logic                 irqOut,
  input logic                 fastOut
);

  localparam logic [ADDR_W-1:0] MASK_N = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] MASK_F = ADDR_W'(6'h24);

  logic wrMaskN, wrMaskF, rdMaskN;
  logic everEnN, everEnF;

  assign wrMaskN = busSel && busWr && (busAddr == MASK_N);
  assign wrMaskF = busSel && busWr && (busAddr == MASK_F);
  assign rdMaskN = busSel && !busWr && (busAddr == MASK_N);

  // Records whether any nonzero mask has ever been written to each bank.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      everEnN <= 1'b0;
      everEnF <= 1'b0;
    end else begin
      if (wrMaskN && (busWdata != '0)) everEnN <= 1'b1;
      if (wrMaskF && (busWdata != '0)) everEnF <= 1'b1;
    end
  end

  // R1 / R9: no output can rise before its bank has been enabled.
  p_quiet_normal_r1: assert property (@(posedge clk) disable iff (!rstN)
    !everEnN |-> !irqOut);
  p_quiet_fast_r9: assert property (@(posedge clk) disable iff (!rstN)
    !everEnF |-> !fastOut);

  // R10: a zero mask write silences the normal output in the next cycle.
  p_mask_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrMaskN && (busWdata == '0)) |=> !irqOut);

  // R2: a mask write followed by a read after one idle cycle returns it.
  p_mask_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrMaskN ##1 !(busSel && busWr) ##1 rdMaskN |=> (busRdata == $past(busWdata, 3)));

  // R11: unmapped word indices read zero in the following cycle.
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && (busAddr[4:3] == 2'b11)) |=> (busRdata == '0));

endmodule

bind dual_irq_ctrl dic_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .fastOut (fastOut)
);

// File: tb/sim_dual_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dual_irq_ctrl;

  localparam int N = 32;
  localparam logic [5:0] RAW0 = 6'h00, MASK0 = 6'h04, CLR0 = 6'h08,
                         MODE0 = 6'h0C, POL0 = 6'h10, STAT0 = 6'h14;
  localparam logic [5:0] RAW1 = 6'h20, MASK1 = 6'h24, CLR1 = 6'h28,
                         MODE1 = 6'h2C, POL1 = 6'h30, STAT1 = 6'h34;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0;
  logic         busWr = 1'b0;
  logic [5:0]   busAddr = '0;
  logic [N-1:0] busWdata = '0;
  logic [N-1:0] busRdata;
  logic [N-1:0] irqIn = '0;
  logic         irqOut, fastOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [N-1:0] data;
    string        tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  dual_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqIn(irqIn), .irqOut(irqOut), .fastOut(fastOut)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [N-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // Driver: push the expected word, then issue the read.
  task automatic rd(input logic [5:0] a, input logic [N-1:0] exp, input string tag);
    expQ.push_back('{exp, tag});
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic chkOut(input logic expN, input logic expF, input string tag);
    checks++;
    if (irqOut !== expN || fastOut !== expF) begin
      errors++;
      $display("FAIL %s outputs got %b%b exp %b%b", tag, irqOut, fastOut, expN, expF);
    end
  endtask

  task automatic setIn(input logic [N-1:0] v);
    @(negedge clk);
    irqIn = v;
  endtask

  // Monitor: compare each read result one cycle after its access.
  initial begin
    forever begin
      bit wasRead;
      exp_t e;
      @(posedge clk);
      wasRead = busSel && !busWr && rstN;
      @(negedge clk);
      if (wasRead && expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (busRdata !== e.data) begin
          errors++;
          $display("FAIL %s read got %h exp %h", e.tag, busRdata, e.data);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    chkOut(1'b0, 1'b0, "R1");
    rd(MASK0, '0, "R1 mask0");
    rd(MODE0, '0, "R1 mode0");
    rd(POL1,  '0, "R1 pol1");
    rd(MASK1, '0, "R1 mask1");

    // R2 read-back and bank independence
    wr(MASK0, 32'hA5A5_0F0F);
    rd(MASK0, 32'hA5A5_0F0F, "R2 mask0");
    wr(MASK1, 32'h1234_5678);
    rd(MASK1, 32'h1234_5678, "R2 mask1");
    rd(MASK0, 32'hA5A5_0F0F, "R2 mask0 kept");
    wr(MODE1, 32'h0000_000F);
    rd(MODE1, 32'h0000_000F, "R2 mode1");
    wr(POL0, 32'h00FF_0000);
    rd(POL0, 32'h00FF_0000, "R2 pol0");
    rd(POL1, '0, "R2 pol1 kept");
    wr(POL0, '0);
    wr(MASK1, '0);

    // R3 level active high
    wr(MASK0, '1);
    setIn(32'h0000_0010);
    idle(4);
    rd(RAW0,  32'h0000_0010, "R3 raw0");
    rd(STAT0, 32'h0000_0010, "R3 stat0");
    chkOut(1'b1, 1'b0, "R3 R9");
    wr(CLR0, 32'h0000_0010);
    rd(RAW0, 32'h0000_0010, "R7 level unaffected");
    setIn('0);
    idle(4);
    rd(STAT0, '0, "R3 stat0 drop");
    chkOut(1'b0, 1'b0, "R3 R9 low");

    // R4 level active low
    wr(POL0, 32'h0000_0100);
    idle(3);
    rd(RAW0, 32'h0000_0100, "R4 low active");
    chkOut(1'b1, 1'b0, "R4 out");
    setIn(32'h0000_0100);
    idle(4);
    rd(RAW0, '0, "R4 high inactive");
    chkOut(1'b0, 1'b0, "R4 out low");
    wr(POL0, '0);
    setIn('0);
    idle(4);

    // R5 rising edge, sticky
    wr(MASK1, '1);
    setIn(32'h0000_0001);
    idle(2);
    irqIn = '0;
    idle(5);
    rd(RAW1,  32'h0000_0001, "R5 raw1");
    rd(STAT1, 32'h0000_0001, "R5 stat1");
    chkOut(1'b0, 1'b1, "R5 R9");

    // R6 falling edge
    wr(POL1, 32'h0000_0002);
    idle(3);
    rd(RAW1, 32'h0000_0001, "R6 pol change no edge");
    setIn(32'h0000_0002);
    idle(4);
    rd(RAW1, 32'h0000_0001, "R6 rise ignored");
    chkOut(1'b1, 1'b1, "R6 R9 both");
    setIn('0);
    idle(4);
    rd(RAW1, 32'h0000_0003, "R6 fall latched");
    chkOut(1'b0, 1'b1, "R6 out");

    // R7 write-one-to-clear
    wr(CLR1, 32'h0000_0002);
    rd(RAW1, 32'h0000_0001, "R7 clear one bit");
    wr(CLR1, '0);
    rd(RAW1, 32'h0000_0001, "R7 zero no effect");
    wr(CLR1, 32'h0000_0001);
    rd(RAW1, '0, "R7 cleared");
    chkOut(1'b0, 1'b0, "R7 out");

    // R10 masking
    setIn(32'h0000_0004);
    idle(4);
    irqIn = '0;
    idle(4);
    rd(RAW1, 32'h0000_0004, "R10 latched");
    wr(MASK1, '0);
    chkOut(1'b0, 1'b0, "R10 out masked");
    rd(STAT1, '0, "R10 stat masked");
    rd(RAW1, 32'h0000_0004, "R10 raw kept");
    wr(MASK1, '1);
    chkOut(1'b0, 1'b1, "R10 out unmasked");
    wr(CLR1, 32'h0000_0004);

    // R8 edge beats simultaneous clear
    setIn(32'h0000_0008);
    idle(4);
    irqIn = '0;
    idle(4);
    rd(RAW1, 32'h0000_0008, "R8 first latch");
    setIn(32'h0000_0008);
    idle(1);
    wr(CLR1, 32'h0000_0008);
    idle(2);
    rd(RAW1, 32'h0000_0008, "R8 edge wins");
    wr(CLR1, 32'h0000_0008);
    rd(RAW1, '0, "R7 steady high clears");
    setIn('0);
    idle(4);

    // R11 map edges
    rd(6'h18, '0, "R11 unmapped 6");
    rd(6'h3C, '0, "R11 unmapped 7");
    rd(CLR0, '0, "R11 clear reads 0");
    wr(MASK0, 32'h0000_FFFF);
    wr(STAT0, 32'hFFFF_0000);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h05, 32'h0F0F_0F0F);
    rd(MASK0, 32'h0000_FFFF, "R11 writes ignored");
    rd(MODE0, '0, "R11 mode0 untouched");
    rd(6'h05, '0, "R11 misaligned read");
    wr(RAW1, '1);
    rd(RAW1, '0, "R11 raw write ignored");

    idle(3);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11 %0d reads unanswered exp 0", expQ.size());
    end
    finishRun();
  end

endmodule